// File: doc/BRIEF.md
# Pattern-Table Line Auto-Select

This block drives the pattern-table address line (bit 12 of the character memory address) for a cartridge mapper. With automatic mode off, the line is a plain copy of the video chip's address bit 12. With automatic mode on, the block watches the video chip's accesses. Each time address bit 13 rises, which marks the start of a nametable fetch, it stores the value of address bit 9. During video reads, that stored bit picks the pattern-table half. Because of this, the background can use one pattern table in the upper rows of the screen and the other in the lower rows, with no CPU involvement.

Video writes always go to the half named by address bit 12, whatever the mode. The mode bit comes from a CPU-writable register held elsewhere in the mapper. The video bus inputs are taken as already synchronous to `clk`. A rising edge of bit 13 is seen when a clock edge samples it high after a clock edge that sampled it low.

Top module: `chr_a12_autosw`

## Requirements
- R1: While `auto_en` is 0, `chr_a12` equals `ppu_a12` in every cycle, for reads and for writes.
- R2: On every clock edge that samples `ppu_a13` high, after the previous edge sampled it low, the stored select bit takes the value of `ppu_a9` sampled at that same edge. The new value is visible from the following cycle. Capture happens whatever the state of `auto_en`.
- R3: While `auto_en` is 1 and `ppu_rd_n` is 0 (a read), `chr_a12` equals the stored select bit.
- R4: While `auto_en` is 1 and `ppu_rd_n` is 1 (no read, including writes), `chr_a12` equals `ppu_a12`.
- R5: After reset, the stored select bit is 0. A read in automatic mode before any rising edge of `ppu_a13` gives `chr_a12` = 0.
- R6: The stored bit holds across any number of accesses. Changes on `ppu_a9` while `ppu_a13` stays high or stays low have no effect on the read output.
- R7: Switching `auto_en` off and back on does not clear or alter the stored bit.
- R8: A rising edge of `ppu_a13` during a write (`ppu_rd_n` = 1) captures `ppu_a9` just as a read does.
- R9: The output path is combinational. `chr_a12` changes within the same cycle in which `ppu_rd_n` or `auto_en` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at which the video bus is sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Automatic pattern-table mode, from the mapper mode register |
| ppu_a13 | input | 1 | Video address bit 13 (high on a nametable fetch) |
| ppu_a12 | input | 1 | Video address bit 12 |
| ppu_a9 | input | 1 | Video address bit 9 |
| ppu_rd_n | input | 1 | Video read strobe, active low |
| chr_a12 | output | 1 | Pattern-table address line to character memory |

## Verification
The assertions take for granted that the video bus inputs are synchronous to `clk` and stay steady across each clock edge. They also assume `ppu_a13` is low when reset is released, so the first edge seen is a real nametable start. The stimulus drives every input shortly after a rising clock edge and holds `ppu_a13` low through reset. It models nametable fetches as one or more cycles with bit 13 high, followed by pattern fetches with bit 13 low. The only mid-cycle input changes are on `ppu_rd_n` and `auto_en`, to show the combinational path; these never cross a clock edge.

// File: rtl/chr_a12_autosw_pkg.sv
package chr_a12_autosw_pkg;
  typedef struct packed {
    logic a13;
    logic a12;
    logic a9;
    logic rd_n;
  } vbus_t;

  localparam logic SEL_RESET = 1'b0;
endpackage

// File: rtl/chr_edge_det.sv
module chr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  assert_rise_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> level_q);
endmodule

// File: rtl/chr_sel_latch.sv
module chr_sel_latch #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic d_i,
  output logic sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_o <= RESET_VAL;
    else if (capture_i) sel_o <= d_i;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> sel_o == $past(d_i));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(sel_o));
endmodule

// File: rtl/chr_a12_mux.sv
module chr_a12_mux (
  input  logic auto_en_i,
  input  logic rd_n_i,
  input  logic stored_i,
  input  logic pass_i,
  output logic line_o
);
  always_comb begin
    if (auto_en_i && !rd_n_i) line_o = stored_i;
    else                      line_o = pass_i;
  end
endmodule

// File: rtl/chr_a12_autosw.sv
module chr_a12_autosw
  import chr_a12_autosw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic ppu_a13,
  input  logic ppu_a12,
  input  logic ppu_a9,
  input  logic ppu_rd_n,
  output logic chr_a12
);
  vbus_t bus;
  logic  nt_start;
  logic  sel_q;

  assign bus = '{a13: ppu_a13, a12: ppu_a12, a9: ppu_a9, rd_n: ppu_rd_n};

  chr_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (bus.a13),
    .rise_o  (nt_start)
  );

  chr_sel_latch #(.RESET_VAL(SEL_RESET)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (nt_start),
    .d_i       (bus.a9),
    .sel_o     (sel_q)
  );

  chr_a12_mux u_mux (
    .auto_en_i (auto_en),
    .rd_n_i    (bus.rd_n),
    .stored_i  (sel_q),
    .pass_i    (bus.a12),
    .line_o    (chr_a12)
  );

  assert_read_follows_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !ppu_rd_n && $past(nt_start)) |-> chr_a12 == $past(ppu_a9));
endmodule

// File: tb/sim_chr_a12_autosw.sv
`timescale 1ns/1ps
module sim_chr_a12_autosw;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, a13 = 1'b0, a12 = 1'b0, a9 = 1'b0, rd_n = 1'b1;
  logic chr_a12;

  int n_checks = 0;
  int n_fail = 0;
  int m_sel = 0;
  int m_prev = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chr_a12_autosw u0 (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .ppu_a13(a13),
    .ppu_a12(a12), .ppu_a9(a9), .ppu_rd_n(rd_n), .chr_a12(chr_a12)
  );

  // Behavioural reference: a remembered bit and the last sampled A13.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel  = 0;
      m_prev = 0;
    end else begin
      if (a13 && m_prev == 0) m_sel = int'(a9);
      m_prev = int'(a13);
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: chr_a12=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!auto_en)   check(chr_a12, a12, "R1");
      else if (rd_n)  check(chr_a12, a12, "R4");
      else            check(chr_a12, m_sel[0], "R3");
    end
  end

  task automatic drive(input logic en, input logic h13, input logic h12,
                       input logic h9, input logic rn);
    @(posedge clk); #1;
    auto_en = en; a13 = h13; a12 = h12; a9 = h9; rd_n = rn;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R5: reset value of the stored bit seen through an automatic read
    drive(1, 0, 1, 1, 0);
    @(negedge clk); check(chr_a12, 1'b0, "R5");

    // Nametable fetch with A9=1 then pattern reads: R2, R3
    drive(1, 1, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    @(negedge clk); check(chr_a12, 1'b1, "R2");
    // R6: A9 wiggles while A13 low
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 0);
    drive(1, 0, 0, 0, 0);
    @(negedge clk); check(chr_a12, 1'b1, "R6");
    // R6: A13 stays high across several cycles with A9 changing
    drive(1, 1, 0, 0, 0);
    drive(1, 1, 0, 1, 0);
    drive(1, 0, 1, 1, 0);
    @(negedge clk); check(chr_a12, 1'b0, "R6");

    // R4: write in automatic mode uses A12
    drive(1, 0, 1, 0, 1);
    @(negedge clk); check(chr_a12, 1'b1, "R4");

    // R8: A13 rises during a write, capture still happens
    drive(1, 1, 0, 1, 1);
    drive(1, 0, 0, 0, 0);
    @(negedge clk); check(chr_a12, 1'b1, "R8");

    // R7: toggle enable, stored bit survives
    drive(0, 0, 0, 0, 0);
    @(negedge clk); check(chr_a12, 1'b0, "R1");
    drive(1, 0, 0, 0, 0);
    @(negedge clk); check(chr_a12, 1'b1, "R7");

    // R9: mid-cycle change of the read strobe and enable
    @(negedge clk); #0.5 rd_n = 1'b1;
    #0.5 check(chr_a12, 1'b0, "R9");
    #0.5 rd_n = 1'b0;
    #0.5 check(chr_a12, 1'b1, "R9");
    @(posedge clk); #1;
    @(negedge clk); #0.5 auto_en = 1'b0;
    #0.5 check(chr_a12, a12, "R9");

    // Randomised frames: nametable fetch then pattern fetches
    for (int f = 0; f < 400; f++) begin
      logic en_v;
      en_v = ($urandom_range(0, 7) != 0);
      drive(en_v, 1, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 3; k++)
        drive(en_v, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 3) == 0));
    end
    drive(1, 0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule